// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block merges the interrupt causes of a UART channel into one active-low interrupt pin and the byte that software reads to learn which cause is being served. Seven causes compete: a receive line error, a receive timeout, the receive FIFO reaching its trigger, the transmit FIFO reaching its trigger, a modem-status change, detection of an Xoff or special character, and a change on the CTS/RTS flow-control lines. Each cause is gated by its interrupt-enable bit, and only the highest-priority gated cause is reported.

Trigger thresholds are derived here. Each direction has a two-bit coarse selector (8, 16, 56 or 60) and a four-bit fine nibble. A nonzero nibble takes over and gives four times its value. The receive trigger is met when the stored character count reaches the threshold. The transmit trigger is met when the free-space count reaches its threshold. Detection of the raw events is done by neighbouring logic. This block receives line-error, timeout and modem-change as levels, and receives Xoff and flow-line changes as one-cycle pulses.

Top module: `uart_irq_ident`

## Requirements
- R1: Among enabled pending causes, the reported one follows the order line error (code 0x03), receive timeout (0x06), receive trigger (0x02), transmit trigger (0x01), modem change (0x00), Xoff/special character (0x08), flow-line change (0x10), highest first; the code sits in `iir[5:1]`.
- R2: `iir[0]` is 0 while any enabled cause is pending and 1 otherwise; with nothing pending `iir[5:1]` is 0.
- R3: `iir[7]` and `iir[6]` both equal `fifo_en`, whatever else is pending.
- R4: With the receive nibble (`tlr[7:4]`) zero, `rx_sel` values 0,1,2,3 give a receive threshold of 8,16,56,60. The receive-trigger cause is pending exactly while `rx_count` is at or above the threshold, and it clears as soon as the count falls below.
- R5: A nonzero nibble replaces the selector with four times its value. The receive nibble is `tlr[7:4]` and the transmit nibble is `tlr[3:0]`. `tx_sel` encodes its thresholds like `rx_sel`.
- R6: The transmit-trigger cause latches on the first clock edge at which `tx_free` is at or above its threshold after having been below it. Reset counts as below. It stays latched until a clock edge that sees `thr_wr`, or that sees `iir_rd` while transmit trigger is the reported cause. A new crossing in that same cycle wins.
- R7: A pulse on `xoff_hit` or `flow_chg` latches its cause. The cause stays latched until a clock edge that sees `iir_rd` while that cause is the reported one. Latching happens whether or not the cause is enabled.
- R8: Enable mapping: `ier_lo[0]` gates receive timeout and receive trigger; `ier_lo[1]` gates transmit trigger; `ier_lo[2]` gates line error; `ier_lo[3]` gates modem change; `ier_hi[0]` (IER bit 5) gates Xoff; `ier_hi[1]` or `ier_hi[2]` (IER bits 6, 7) gate flow-line change. A gated-off cause is neither reported nor blocks a lower one. `irq_n` is low exactly while some enabled cause is pending.
- R9: After reset all latched causes are clear, so with no level causes and no enables `irq_n` is 1 and `iir` is 0x01 with `fifo_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable, mirrored into `iir[7:6]` |
| rx_sel | input | 2 | Coarse receive trigger selector |
| tx_sel | input | 2 | Coarse transmit trigger selector |
| tlr | input | 8 | Fine trigger nibbles: receive [7:4], transmit [3:0] |
| ier_lo | input | 4 | Interrupt enables, IER bits 3:0 |
| ier_hi | input | 3 | Interrupt enables, IER bits 7:5 |
| rx_count | input | 7 | Characters stored in the receive FIFO |
| tx_free | input | 7 | Free spaces in the transmit FIFO |
| line_err | input | 1 | Line error pending (level) |
| rx_tmo | input | 1 | Receive timeout pending (level) |
| modem_chg | input | 1 | Modem status change pending (level) |
| xoff_hit | input | 1 | Xoff/special character detected (pulse) |
| flow_chg | input | 1 | Flow-control line changed (pulse) |
| iir_rd | input | 1 | Identification byte is being read (pulse) |
| thr_wr | input | 1 | Transmit holding register written (pulse) |
| irq_n | output | 1 | Interrupt, active low |
| iir | output | 8 | Interrupt identification byte |

## Verification
The bench targets the modem-change cause. Its code is zero, so only `iir[0]` tells it apart from an idle state, and a design that reported it as "none" would leave `irq_n` and `iir[0]` disagreeing. It drives thresholds at both selector extremes and with overriding nibbles, one count below and exactly at each threshold. This catches an off-by-one compare or a nibble that fails to override. It checks that an identification read clears only the cause it reported. A design that clears every latched cause, or clears the transmit trigger while a higher cause is shown, loses the pending Xoff or flow-line cause that the reference model still expects. Random traffic then checks that masked causes do not hide lower enabled ones.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   localparam int NUM_SRC = 7;

   typedef enum logic [2:0] {
      SRC_LINE = 3'd0,
      SRC_TMO  = 3'd1,
      SRC_RXT  = 3'd2,
      SRC_THR  = 3'd3,
      SRC_MDM  = 3'd4,
      SRC_XOFF = 3'd5,
      SRC_FLOW = 3'd6
   } src_e;

   function automatic logic [4:0] src_code(input src_e s);
      case (s)
         SRC_LINE: return 5'h03;
         SRC_TMO:  return 5'h06;
         SRC_RXT:  return 5'h02;
         SRC_THR:  return 5'h01;
         SRC_MDM:  return 5'h00;
         SRC_XOFF: return 5'h08;
         default:  return 5'h10;
      endcase
   endfunction

   function automatic int coarse_trig(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8;
         2'd1:    return 16;
         2'd2:    return 56;
         default: return 60;
      endcase
   endfunction

endpackage

// File: rtl/uirq_trig.sv
module uirq_trig #(
   parameter int LVL_W     = 7,
   parameter int TRIG_STEP = 4
) (
   input  logic [1:0]       sel,
   input  logic [3:0]       nib,
   input  logic [LVL_W-1:0] count,
   output logic             at_trig
);
   import uirq_pkg::*;

   int thresh;

   always_comb begin
      if (nib != 4'd0) thresh = int'(nib) * TRIG_STEP;
      else             thresh = coarse_trig(sel);
      at_trig = int'(count) >= thresh;
   end

endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);

   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[g] <= 1'b0;
         else if (set[g]) flag[g] <= 1'b1;
         else if (clr[g]) flag[g] <= 1'b0;
      end
   end

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
   import uirq_pkg::*;
#(
   parameter int N = NUM_SRC
) (
   input  logic [N-1:0] req,
   output logic         valid,
   output src_e         win
);

   always_comb begin
      valid = 1'b0;
      win   = SRC_LINE;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            valid = 1'b1;
            win   = src_e'(i[2:0]);
         end
      end
   end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uirq_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int TRIG_STEP  = 4,
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic [1:0]       rx_sel,
   input  logic [1:0]       tx_sel,
   input  logic [7:0]       tlr,
   input  logic [3:0]       ier_lo,
   input  logic [2:0]       ier_hi,
   input  logic [LVL_W-1:0] rx_count,
   input  logic [LVL_W-1:0] tx_free,
   input  logic             line_err,
   input  logic             rx_tmo,
   input  logic             modem_chg,
   input  logic             xoff_hit,
   input  logic             flow_chg,
   input  logic             iir_rd,
   input  logic             thr_wr,
   output logic             irq_n,
   output logic [7:0]       iir
);

   if (FIFO_DEPTH < 60) begin : g_depth_chk
      $error("FIFO_DEPTH must hold the largest trigger of 60");
   end
   if (TRIG_STEP * 15 > FIFO_DEPTH) begin : g_step_chk
      $error("TRIG_STEP times 15 exceeds FIFO_DEPTH");
   end

   localparam int F_THR  = 0;
   localparam int F_XOFF = 1;
   localparam int F_FLOW = 2;

   logic                rx_hit, tx_ok, tx_ok_q;
   logic [2:0]          st_set, st_clr, st_flag;
   logic [NUM_SRC-1:0]  req;
   logic                any_req;
   src_e                win;

   uirq_trig #(.LVL_W(LVL_W), .TRIG_STEP(TRIG_STEP)) rx_trig_i (
      .sel(rx_sel), .nib(tlr[7:4]), .count(rx_count), .at_trig(rx_hit));

   uirq_trig #(.LVL_W(LVL_W), .TRIG_STEP(TRIG_STEP)) tx_trig_i (
      .sel(tx_sel), .nib(tlr[3:0]), .count(tx_free), .at_trig(tx_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_ok_q <= 1'b0;
      else        tx_ok_q <= tx_ok;
   end

   always_comb begin
      st_set         = '0;
      st_clr         = '0;
      st_set[F_THR]  = tx_ok & ~tx_ok_q;
      st_set[F_XOFF] = xoff_hit;
      st_set[F_FLOW] = flow_chg;
      st_clr[F_THR]  = thr_wr | (iir_rd & any_req & (win == SRC_THR));
      st_clr[F_XOFF] = iir_rd & any_req & (win == SRC_XOFF);
      st_clr[F_FLOW] = iir_rd & any_req & (win == SRC_FLOW);
   end

   uirq_sticky #(.N(3)) sticky_i (
      .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr), .flag(st_flag));

   always_comb begin
      req           = '0;
      req[SRC_LINE] = line_err & ier_lo[2];
      req[SRC_TMO]  = rx_tmo & ier_lo[0];
      req[SRC_RXT]  = rx_hit & ier_lo[0];
      req[SRC_THR]  = st_flag[F_THR] & ier_lo[1];
      req[SRC_MDM]  = modem_chg & ier_lo[3];
      req[SRC_XOFF] = st_flag[F_XOFF] & ier_hi[0];
      req[SRC_FLOW] = st_flag[F_FLOW] & (ier_hi[1] | ier_hi[2]);
   end

   uirq_prio #(.N(NUM_SRC)) prio_i (.req(req), .valid(any_req), .win(win));

   assign irq_n = ~(|req);
   assign iir   = {fifo_en, fifo_en, any_req ? src_code(win) : 5'h00, ~any_req};

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
   parameter int LVL_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_en,
   input logic [3:0]       ier_lo,
   input logic [2:0]       ier_hi,
   input logic [LVL_W-1:0] rx_count,
   input logic             line_err,
   input logic             rx_tmo,
   input logic             xoff_hit,
   input logic             irq_n,
   input logic [7:0]       iir
);

   // R2: pin and pending flag of the identification byte agree
   p_pin_matches_iir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n == iir[0]);

   // R3: both upper bits mirror the FIFO enable
   p_fifo_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iir[7] == fifo_en) && (iir[6] == fifo_en));

   // R1: an enabled line error always wins
   p_line_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (line_err && ier_lo[2]) |-> (iir[5:1] == 5'h03 && !iir[0]));

   // R4: a count of 60 or more meets every receive threshold
   p_rx_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_lo[0] && !(line_err && ier_lo[2]) && !rx_tmo && rx_count >= 7'd60)
      |-> (iir[5:1] == 5'h02));

   // R7: an enabled Xoff pulse leaves an interrupt pending next cycle
   p_xoff_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xoff_hit && ier_hi[0]) |=> (!irq_n || !ier_hi[0]));

   // R8: with every enable off the pin stays inactive
   p_all_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_lo == 4'd0 && ier_hi == 3'd0) |-> (irq_n && iir[5:0] == 6'h01));

endmodule

bind uart_irq_ident uirq_chk #(.LVL_W(LVL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier_lo(ier_lo), .ier_hi(ier_hi),
   .rx_count(rx_count), .line_err(line_err), .rx_tmo(rx_tmo), .xoff_hit(xoff_hit),
   .irq_n(irq_n), .iir(iir));

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b0;
   logic [1:0] rx_sel = '0, tx_sel = '0;
   logic [7:0] tlr = '0;
   logic [3:0] ier_lo = '0;
   logic [2:0] ier_hi = '0;
   logic [6:0] rx_count = '0, tx_free = '0;
   logic       line_err = 0, rx_tmo = 0, modem_chg = 0, xoff_hit = 0, flow_chg = 0;
   logic       iir_rd = 0, thr_wr = 0;
   logic       irq_n;
   logic [7:0] iir;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // reference model state
   bit m_thr = 0, m_xoff = 0, m_flow = 0, m_txok_prev = 0;

   always #(CLK_P/2) clk = ~clk;

   uart_irq_ident dut_i (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_sel(rx_sel), .tx_sel(tx_sel),
      .tlr(tlr), .ier_lo(ier_lo), .ier_hi(ier_hi), .rx_count(rx_count),
      .tx_free(tx_free), .line_err(line_err), .rx_tmo(rx_tmo), .modem_chg(modem_chg),
      .xoff_hit(xoff_hit), .flow_chg(flow_chg), .iir_rd(iir_rd), .thr_wr(thr_wr),
      .irq_n(irq_n), .iir(iir));

   function automatic int thresh(input logic [1:0] sel, input logic [3:0] nib);
      int t;
      if (nib != 0) t = nib * 4;
      else begin
         t = (sel == 0) ? 8 : (sel == 1) ? 16 : (sel == 2) ? 56 : 60;
      end
      return t;
   endfunction

   // returns -1 when nothing is pending, otherwise the source code
   function automatic int ref_code();
      if (line_err && ier_lo[2]) return 3;
      if (rx_tmo && ier_lo[0]) return 6;
      if (rx_count >= thresh(rx_sel, tlr[7:4]) && ier_lo[0]) return 2;
      if (m_thr && ier_lo[1]) return 1;
      if (modem_chg && ier_lo[3]) return 0;
      if (m_xoff && ier_hi[0]) return 8;
      if (m_flow && (ier_hi[1] || ier_hi[2])) return 16;
      return -1;
   endfunction

   function automatic logic [7:0] ref_iir();
      int c;
      c = ref_code();
      if (c < 0) return {fifo_en, fifo_en, 6'h01};
      return {fifo_en, fifo_en, c[4:0], 1'b0};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_thr <= 0; m_xoff <= 0; m_flow <= 0; m_txok_prev <= 0;
      end else begin
         int c;
         bit txok;
         c = ref_code();
         txok = tx_free >= thresh(tx_sel, tlr[3:0]);
         m_txok_prev <= txok;
         if (txok && !m_txok_prev) m_thr <= 1;
         else if (thr_wr || (iir_rd && c == 1)) m_thr <= 0;
         if (xoff_hit) m_xoff <= 1;
         else if (iir_rd && c == 8) m_xoff <= 0;
         if (flow_chg) m_flow <= 1;
         else if (iir_rd && c == 16) m_flow <= 0;
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [7:0] e;
         e = ref_iir();
         n_tests++;
         if (iir !== e || irq_n !== e[0]) begin
            n_fail++;
            if (iir[7:6] !== e[7:6])
               $display("FAIL R3 model: iir=%02h irq_n=%b expected iir=%02h", iir, irq_n, e);
            else if (irq_n !== e[0])
               $display("FAIL R8 model: iir=%02h irq_n=%b expected iir=%02h", iir, irq_n, e);
            else
               $display("FAIL R1 model: iir=%02h expected %02h", iir, e);
         end
      end
   end

   task automatic step();
      @(negedge clk);
      #(CLK_P/4);
   endtask

   task automatic chk(input string tag, input logic [7:0] exp_iir);
      n_tests++;
      if (iir !== exp_iir || irq_n !== exp_iir[0]) begin
         n_fail++;
         $display("FAIL %s: iir=%02h irq_n=%b expected iir=%02h irq_n=%b",
                  tag, iir, irq_n, exp_iir, exp_iir[0]);
      end
   endtask

   task automatic rd_pulse();
      iir_rd = 1; step(); iir_rd = 0; step();
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      chk("R9 reset", 8'h01);
      rst_n = 1; step();
      chk("R9 after reset", 8'h01);
      fifo_en = 1; step();
      chk("R3 mirror", 8'hC1);

      // R4 coarse receive thresholds
      ier_lo = 4'h1; rx_sel = 2'd1; rx_count = 16; step(); step();
      chk("R4 rx 16 at", 8'hC4);
      rx_count = 15; step();
      chk("R4 rx 16 below", 8'hC1);
      rx_sel = 2'd3; rx_count = 60; step();
      chk("R4 rx 60 at", 8'hC4);
      rx_count = 59; step();
      chk("R4 rx 60 below", 8'hC1);
      rx_sel = 2'd0; rx_count = 8; step();
      chk("R4 rx 8 at", 8'hC4);

      // R5 fine nibble overrides
      rx_sel = 2'd3; tlr = 8'h30; rx_count = 12; step();
      chk("R5 rx nibble at", 8'hC4);
      rx_count = 11; step();
      chk("R5 rx nibble below", 8'hC1);
      tlr = 8'h00; rx_count = 0;

      // R6 transmit trigger latch and clears
      ier_lo = 4'h2; tx_sel = 2'd0; tx_free = 4; step(); step();
      chk("R6 tx below", 8'hC1);
      tx_free = 8; step(); step();
      chk("R6 tx crossing", 8'hC2);
      tx_free = 20; step(); step();
      chk("R6 tx held", 8'hC2);
      rd_pulse();
      chk("R6 cleared by read", 8'hC1);
      tx_free = 4; step(); tx_free = 8; step(); step();
      chk("R6 second crossing", 8'hC2);
      thr_wr = 1; step(); thr_wr = 0; step();
      chk("R6 cleared by write", 8'hC1);
      tlr = 8'h05; step(); tx_free = 20; step(); step();
      chk("R5 tx nibble crossing", 8'hC2);
      rd_pulse();
      chk("R6 read after nibble", 8'hC1);
      tlr = 8'h00; tx_free = 4; step();

      // R7 latched pulse causes
      ier_lo = 4'h0; ier_hi = 3'b001;
      xoff_hit = 1; step(); xoff_hit = 0; step();
      chk("R7 xoff latched", 8'hD0);
      step();
      chk("R7 xoff held", 8'hD0);
      rd_pulse();
      chk("R7 xoff cleared", 8'hC1);
      ier_hi = 3'b010; flow_chg = 1; step(); flow_chg = 0; step();
      chk("R7 flow latched", 8'hE0);
      ier_hi = 3'b000; step();
      chk("R8 flow masked", 8'hC1);
      ier_hi = 3'b100; step();
      chk("R8 flow via bit 7", 8'hE0);
      rd_pulse();
      chk("R7 flow cleared", 8'hC1);

      // R1 full priority ladder
      ier_lo = 4'hF; ier_hi = 3'b111; rx_sel = 2'd0;
      line_err = 1; rx_tmo = 1; rx_count = 8; modem_chg = 1; tx_free = 64;
      xoff_hit = 1; flow_chg = 1; step();
      xoff_hit = 0; flow_chg = 0; step();
      chk("R1 line first", 8'hC6);
      rd_pulse();
      chk("R1 read keeps line", 8'hC6);
      line_err = 0; step();
      chk("R1 timeout next", 8'hCC);
      rx_tmo = 0; step();
      chk("R1 rx trigger next", 8'hC4);
      rx_count = 0; step();
      chk("R1 thr next", 8'hC2);
      rd_pulse();
      chk("R2 modem code zero pending", 8'hC0);
      modem_chg = 0; step();
      chk("R1 xoff next", 8'hD0);
      rd_pulse();
      chk("R1 flow last", 8'hE0);
      // R8 masked higher cause does not block lower
      line_err = 1; ier_lo = 4'h0; step();
      chk("R8 masked line", 8'hE0);
      rd_pulse();
      chk("R2 idle", 8'hC1);
      line_err = 0;

      // random traffic checked by the model every cycle
      for (int i = 0; i < 4000; i++) begin
         step();
         fifo_en   = $urandom % 2;
         rx_sel    = $urandom % 4;
         tx_sel    = $urandom % 4;
         tlr[7:4]  = ($urandom % 2) ? 4'd0 : 4'($urandom % 16);
         tlr[3:0]  = ($urandom % 2) ? 4'd0 : 4'($urandom % 16);
         ier_lo    = 4'($urandom);
         ier_hi    = 3'($urandom);
         rx_count  = 7'($urandom % 65);
         tx_free   = 7'($urandom % 65);
         line_err  = ($urandom % 10) == 0;
         rx_tmo    = ($urandom % 10) == 0;
         modem_chg = ($urandom % 7) == 0;
         xoff_hit  = ($urandom % 12) == 0;
         flow_chg  = ($urandom % 12) == 0;
         iir_rd    = ($urandom % 3) == 0;
         thr_wr    = ($urandom % 10) == 0;
      end
      step();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule